// File: doc/BRIEF.md
# PCI Target Base-Address Decoder

This block sits beside a PCI target's handshake state machine. When that state machine raises the address-latch enable, the block captures the AD bus and classifies the bus command. The command is either an accepted configuration access, a qualified I/O or memory access, or nothing.

Two base address registers are held here. They are written by type-0, function-0 configuration writes to byte offsets 0x10 and 0x14, and read back by configuration reads at those offsets. For qualified I/O and memory cycles, the block compares the latched address with the two registers above a parameterised region size. It then returns an active-low hit for region 0 or region 1. The control state machine samples these hits in the cycle after the address phase.

Data for a configuration write is taken from the AD bus in the clock cycle after the address phase. The C/BE# lines in that cycle act as active-low byte enables.

Top module: `tgt_bar_decode`

## Requirements
- R1: While reset is low and after it is released, both hit outputs are 1 (inactive), the latched address is 0, the configuration qualifier is 0 and the read-back data is 0.
- R2: The AD bus is loaded into the latched address on a rising edge only when the latch enable is 1; otherwise the latched address keeps its value.
- R3: A configuration access is accepted at an address phase when C/BE# is 4'b1010 (read) or 4'b1011 (write), IDSEL is 1, FRAME# is 0, AD[10:8] is 3'b000 and AD[1:0] is 2'b00. The configuration qualifier is 1 from the cycle after that address phase until the next one.
- R4: After an accepted configuration write with AD[7:2] = 6'h04 (byte offset 0x10), base register 0 takes the AD bus on the next rising edge. Byte lane i (AD[8i+7:8i]) is written only where C/BE#[i] is 0 in that data cycle.
- R5: The same write rule applies to base register 1 when AD[7:2] = 6'h05 (byte offset 0x14).
- R6: After an accepted configuration read, the read-back output shows base register 0 (offset 0x10) or base register 1 (offset 0x14), with its low REGION_BITS bits forced to 0. Any other offset, and any cycle that is not a configuration read, gives 0.
- R7: C/BE# 4'b0010 or 4'b0011 with IDSEL 0 and FRAME# 0 is an I/O cycle. It can produce a hit only if space-enable bit 0 was 1 at the address phase.
- R8: C/BE# 4'b0110 or 4'b0111 with IDSEL 0 and FRAME# 0 is a memory cycle. It can produce a hit only if space-enable bit 1 was 1 at the address phase.
- R9: For a qualified cycle, a hit output goes to 0 when latched address bits [31:REGION_BITS] equal the same bits of that region's base register. Lower bits are ignored.
- R10: If both regions match, only the region-0 hit goes to 0.
- R11: A rejected configuration write (wrong function number, wrong type bits or IDSEL low) leaves both base registers unchanged and the configuration qualifier at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| adBus | input | 32 | AD bus: address in the address phase, data in the configuration data cycle |
| cbeN | input | 4 | Command in the address phase, active-low byte enables in the data cycle |
| frameN | input | 1 | FRAME#, active low |
| idsel | input | 1 | Configuration select |
| spaceEn | input | 2 | Bit 0 enables I/O decode, bit 1 enables memory decode |
| latchEn | input | 1 | Address-latch enable from the control state machine |
| hit0N | output | 1 | Region 0 hit, active low |
| hit1N | output | 1 | Region 1 hit, active low |
| latchAddr | output | 32 | Latched address |
| cfgAccess | output | 1 | Latched cycle is an accepted configuration access |
| cfgRdData | output | 32 | Base register read-back for configuration reads |

## Verification
Region decode is tried with memory and I/O commands, each with its space-enable bit set and cleared. This separates the per-space qualification from the address compare. Addresses that differ from a base only below the region boundary, and one that differs just above it, show whether the compare uses exactly the upper bits. A case where both base registers hold the same value exposes the priority. Configuration writes use full, partial-lane and rejected forms, each followed by a read-back. These separate lane masking, offset selection, the read-back mask and the acceptance rules.

// File: rtl/tbd_pkg.sv
package tbd_pkg;

  localparam logic [3:0] CMD_IO_RD  = 4'b0010;
  localparam logic [3:0] CMD_IO_WR  = 4'b0011;
  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;

  // dword index of each base register within configuration space
  localparam logic [5:0] BAR0_IDX = 6'h04;
  localparam logic [5:0] BAR1_IDX = 6'h05;

  typedef enum logic [2:0] {
    CLS_NONE,
    CLS_IO,
    CLS_MEM,
    CLS_CFGRD,
    CLS_CFGWR
  } cycClass_e;

  typedef struct packed {
    logic       capture;
    logic [3:0] laneWr0;
    logic [3:0] laneWr1;
  } dpStrobe_t;

endpackage

// File: rtl/tbd_ctrl.sv
module tbd_ctrl
  import tbd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] adBus,
  input  logic [3:0]        cbeN,
  input  logic              frameN,
  input  logic              idsel,
  input  logic [1:0]        spaceEn,
  input  logic              latchEn,
  input  logic              match0,
  input  logic              match1,
  output dpStrobe_t         strb,
  output logic              hit0N,
  output logic              hit1N,
  output logic              cfgAccess,
  output logic              cfgRead
);

  logic      isIoCmd, isMemCmd, isCfgCmd;
  logic      cfgOk, ioOk, memOk;
  logic      selBar0, selBar1;
  cycClass_e nextCls, curCls;
  logic      pend0, pend1;
  logic      isSpace;

  always_comb begin
    isIoCmd  = (cbeN == CMD_IO_RD)  || (cbeN == CMD_IO_WR);
    isMemCmd = (cbeN == CMD_MEM_RD) || (cbeN == CMD_MEM_WR);
    isCfgCmd = (cbeN == CMD_CFG_RD) || (cbeN == CMD_CFG_WR);
    cfgOk    = isCfgCmd && idsel && !frameN
               && (adBus[10:8] == 3'b000) && (adBus[1:0] == 2'b00);
    ioOk     = isIoCmd  && spaceEn[0] && !idsel && !frameN;
    memOk    = isMemCmd && spaceEn[1] && !idsel && !frameN;
    selBar0  = cfgOk && (cbeN == CMD_CFG_WR) && (adBus[7:2] == BAR0_IDX);
    selBar1  = cfgOk && (cbeN == CMD_CFG_WR) && (adBus[7:2] == BAR1_IDX);
  end

  always_comb begin
    if (cfgOk)
      nextCls = (cbeN == CMD_CFG_RD) ? CLS_CFGRD : CLS_CFGWR;
    else if (ioOk)
      nextCls = CLS_IO;
    else if (memOk)
      nextCls = CLS_MEM;
    else
      nextCls = CLS_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curCls <= CLS_NONE;
      pend0  <= 1'b0;
      pend1  <= 1'b0;
    end else if (latchEn) begin
      curCls <= nextCls;
      pend0  <= selBar0;
      pend1  <= selBar1;
    end else begin
      pend0  <= 1'b0;
      pend1  <= 1'b0;
    end
  end

  always_comb begin
    strb.capture = latchEn;
    strb.laneWr0 = pend0 ? ~cbeN : 4'b0000;
    strb.laneWr1 = pend1 ? ~cbeN : 4'b0000;
  end

  always_comb begin
    isSpace   = (curCls == CLS_IO) || (curCls == CLS_MEM);
    hit0N     = !(isSpace && match0);
    hit1N     = !(isSpace && match1 && !match0);
    cfgAccess = (curCls == CLS_CFGRD) || (curCls == CLS_CFGWR);
    cfgRead   = (curCls == CLS_CFGRD);
  end

endmodule

// File: rtl/tbd_dpath.sv
module tbd_dpath
  import tbd_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int REGION_BITS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] adBus,
  input  dpStrobe_t         strb,
  input  logic              cfgRead,
  output logic [ADDR_W-1:0] latchAddr,
  output logic [ADDR_W-1:0] bar0Q,
  output logic [ADDR_W-1:0] bar1Q,
  output logic              match0,
  output logic              match1,
  output logic [ADDR_W-1:0] cfgRdData
);

  localparam int LANES = ADDR_W / 8;
  localparam logic [ADDR_W-1:0] LOW_MASK = (ADDR_W'(1) << REGION_BITS) - ADDR_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      latchAddr <= '0;
    else if (strb.capture)
      latchAddr <= adBus;
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bar0Q[8*g +: 8] <= '0;
        bar1Q[8*g +: 8] <= '0;
      end else begin
        if (strb.laneWr0[g]) bar0Q[8*g +: 8] <= adBus[8*g +: 8];
        if (strb.laneWr1[g]) bar1Q[8*g +: 8] <= adBus[8*g +: 8];
      end
    end
  end

  always_comb begin
    match0 = (latchAddr[ADDR_W-1:REGION_BITS] == bar0Q[ADDR_W-1:REGION_BITS]);
    match1 = (latchAddr[ADDR_W-1:REGION_BITS] == bar1Q[ADDR_W-1:REGION_BITS]);
  end

  always_comb begin
    cfgRdData = '0;
    if (cfgRead) begin
      if (latchAddr[7:2] == BAR0_IDX)
        cfgRdData = bar0Q & ~LOW_MASK;
      else if (latchAddr[7:2] == BAR1_IDX)
        cfgRdData = bar1Q & ~LOW_MASK;
    end
  end

endmodule

// File: rtl/tgt_bar_decode.sv
module tgt_bar_decode
  import tbd_pkg::*;
#(
  parameter int REGION_BITS = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] adBus,
  input  logic [3:0]  cbeN,
  input  logic        frameN,
  input  logic        idsel,
  input  logic [1:0]  spaceEn,
  input  logic        latchEn,
  output logic        hit0N,
  output logic        hit1N,
  output logic [31:0] latchAddr,
  output logic        cfgAccess,
  output logic [31:0] cfgRdData
);

  localparam int ADDR_W = 32;

  dpStrobe_t         strb;
  logic              cfgRead;
  logic              match0, match1;
  logic [ADDR_W-1:0] bar0Q, bar1Q;

  tbd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .adBus(adBus), .cbeN(cbeN), .frameN(frameN),
    .idsel(idsel), .spaceEn(spaceEn), .latchEn(latchEn),
    .match0(match0), .match1(match1), .strb(strb),
    .hit0N(hit0N), .hit1N(hit1N), .cfgAccess(cfgAccess), .cfgRead(cfgRead)
  );

  tbd_dpath #(.ADDR_W(ADDR_W), .REGION_BITS(REGION_BITS)) u_dpath (
    .clk(clk), .rstN(rstN), .adBus(adBus), .strb(strb), .cfgRead(cfgRead),
    .latchAddr(latchAddr), .bar0Q(bar0Q), .bar1Q(bar1Q),
    .match0(match0), .match1(match1), .cfgRdData(cfgRdData)
  );

endmodule

// File: rtl/tbd_checker.sv
module tbd_checker
  import tbd_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        latchEn,
  input logic [31:0] adBus,
  input logic [31:0] latchAddr,
  input logic        hit0N,
  input logic        hit1N,
  input logic        cfgAccess,
  input dpStrobe_t   strb,
  input logic [31:0] bar0Q,
  input logic [31:0] bar1Q
);

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !latchEn |=> $stable(latchAddr)); // R2

  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    latchEn |=> (latchAddr == $past(adBus))); // R2

  AST_BAR0_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (strb.laneWr0 == 4'b0000) |=> $stable(bar0Q)); // R4

  AST_BAR1_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (strb.laneWr1 == 4'b0000) |=> $stable(bar1Q)); // R5

  AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rstN)
    !(!hit0N && !hit1N)); // R10

  AST_NO_HIT_IN_CFG: assert property (@(posedge clk) disable iff (!rstN)
    cfgAccess |-> (hit0N && hit1N)); // R9

endmodule

bind tgt_bar_decode tbd_checker u_chk (
  .clk(clk), .rstN(rstN), .latchEn(latchEn), .adBus(adBus),
  .latchAddr(latchAddr), .hit0N(hit0N), .hit1N(hit1N),
  .cfgAccess(cfgAccess), .strb(strb), .bar0Q(bar0Q), .bar1Q(bar1Q)
);

// File: tb/sim_tgt_bar_decode.sv
module sim_tgt_bar_decode;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] adBus;
  logic [3:0]  cbeN;
  logic        frameN, idsel, latchEn;
  logic [1:0]  spaceEn;
  logic        hit0N, hit1N, cfgAccess;
  logic [31:0] latchAddr, cfgRdData;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tgt_bar_decode u0 (
    .clk(clk), .rstN(rstN), .adBus(adBus), .cbeN(cbeN), .frameN(frameN),
    .idsel(idsel), .spaceEn(spaceEn), .latchEn(latchEn),
    .hit0N(hit0N), .hit1N(hit1N), .latchAddr(latchAddr),
    .cfgAccess(cfgAccess), .cfgRdData(cfgRdData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // address phase, then one data cycle carrying dAd/dBe; returns at the negedge after it
  task automatic phase(input logic [31:0] a, input logic [3:0] cmd, input logic sel,
                       input logic [1:0] sp, input logic [31:0] dAd, input logic [3:0] dBe);
    @(negedge clk);
    adBus = a; cbeN = cmd; idsel = sel; spaceEn = sp; frameN = 1'b0; latchEn = 1'b1;
    @(negedge clk);
    adBus = dAd; cbeN = dBe; idsel = 1'b0; frameN = 1'b1; latchEn = 1'b0;
  endtask

  task automatic cfgWr(input logic [7:0] ofs, input logic [31:0] d, input logic [3:0] be);
    phase({24'h0, ofs}, 4'b1011, 1'b1, 2'b00, d, be);
    @(negedge clk);
    adBus = '0; cbeN = 4'hF;
  endtask

  task automatic cfgRdCheck(input string req, input logic [7:0] ofs, input logic [31:0] exp);
    phase({24'h0, ofs}, 4'b1010, 1'b1, 2'b00, 32'h0, 4'hF);
    chk(req, {31'h0, cfgAccess}, 32'h1);
    chk(req, cfgRdData, exp);
  endtask

  task automatic spaceCheck(input string req, input logic [31:0] a, input logic [3:0] cmd,
                            input logic [1:0] sp, input logic sel, input logic e0, input logic e1);
    phase(a, cmd, sel, sp, 32'h0, 4'hF);
    chk(req, {30'h0, hit1N, hit0N}, {30'h0, e1, e0});
  endtask

  task automatic tReset;
    chk("R1 hits", {30'h0, hit1N, hit0N}, 32'h3);
    chk("R1 latchAddr", latchAddr, 32'h0);
    chk("R1 cfgAccess", {31'h0, cfgAccess}, 32'h0);
    chk("R1 cfgRdData", cfgRdData, 32'h0);
  endtask

  task automatic tBarWrite;
    cfgWr(8'h10, 32'h1234_56FF, 4'b0000);
    cfgRdCheck("R4 R6 full write masked", 8'h10, 32'h1234_5600);
    cfgWr(8'h10, 32'hAABB_CCDD, 4'b1100);
    cfgRdCheck("R4 lane write", 8'h10, 32'h1234_CC00);
    cfgWr(8'h14, 32'h8000_0000, 4'b0000);
    cfgRdCheck("R5 bar1 write", 8'h14, 32'h8000_0000);
    cfgRdCheck("R6 other offset", 8'h18, 32'h0);
  endtask

  task automatic tDecode;
    spaceCheck("R8 mem hit0", 32'h1234_CC40, 4'b0110, 2'b10, 1'b0, 1'b0, 1'b1);
    chk("R3 no cfg on mem", {31'h0, cfgAccess}, 32'h0);
    chk("R6 no readback on mem", cfgRdData, 32'h0);
    spaceCheck("R8 mem disabled", 32'h1234_CC40, 4'b0111, 2'b01, 1'b0, 1'b1, 1'b1);
    spaceCheck("R7 io hit1", 32'h8000_0010, 4'b0011, 2'b01, 1'b0, 1'b1, 1'b0);
    spaceCheck("R7 io disabled", 32'h8000_0010, 4'b0010, 2'b10, 1'b0, 1'b1, 1'b1);
    spaceCheck("R9 above region", 32'h1234_CD00, 4'b0110, 2'b11, 1'b0, 1'b1, 1'b1);
    spaceCheck("R9 low bits ignored", 32'h1234_CCFF, 4'b0110, 2'b11, 1'b0, 1'b0, 1'b1);
    spaceCheck("R8 idsel high", 32'h1234_CC40, 4'b0110, 2'b11, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic tPriority;
    cfgWr(8'h14, 32'h1234_CC00, 4'b0000);
    spaceCheck("R10 both match", 32'h1234_CC04, 4'b0110, 2'b11, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic tReject;
    phase(32'h0000_0110, 4'b1011, 1'b1, 2'b00, 32'hDEAD_BEEF, 4'b0000);
    chk("R11 bad function qualifier", {31'h0, cfgAccess}, 32'h0);
    @(negedge clk);
    phase(32'h0000_0011, 4'b1011, 1'b1, 2'b00, 32'hDEAD_BEEF, 4'b0000);
    chk("R11 bad type qualifier", {31'h0, cfgAccess}, 32'h0);
    @(negedge clk);
    phase(32'h0000_0010, 4'b1011, 1'b0, 2'b00, 32'hDEAD_BEEF, 4'b0000);
    @(negedge clk);
    cfgRdCheck("R11 bar0 kept", 8'h10, 32'h1234_CC00);
    cfgRdCheck("R3 read accepted bar1", 8'h14, 32'h1234_CC00);
  endtask

  task automatic tLatchHold;
    phase(32'h5555_AA00, 4'b0110, 1'b0, 2'b11, 32'hFFFF_0000, 4'hF);
    chk("R2 captured", latchAddr, 32'h5555_AA00);
    @(negedge clk);
    adBus = 32'h0F0F_0F0F;
    @(negedge clk);
    chk("R2 held without enable", latchAddr, 32'h5555_AA00);
  endtask

  initial begin
    rstN = 1'b0; adBus = '0; cbeN = 4'hF; frameN = 1'b1; idsel = 1'b0;
    spaceEn = 2'b00; latchEn = 1'b0;
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tBarWrite();
    tDecode();
    tPriority();
    tReject();
    tLatchHold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule